// File: doc/BRIEF.md
# Set-Associative Translation Cache with Address-Space Tags

This block holds recently used virtual-to-physical page translations. It has 64 entries arranged as 16 sets of 4 ways. A 32-bit virtual address is split into a 12-bit page offset and a 20-bit virtual page number. The low 4 bits of the page number pick the set, and the upper 16 bits, together with an 8-bit address-space identifier, form the tag. A lookup compares the tags of all four ways of the chosen set in parallel, all within the same cycle. On a hit the block returns the stored frame number with the page offset appended. On a miss it raises a miss flag so that a page table walker can be started.

Translations for several processes can be held at the same time, because the address-space identifier takes part in every match. The walker writes results back through a fill port. A second port removes a single translation, which is used for shootdown and for page eviction. A flush input clears every entry at once. Each entry also keeps a dirty bit. A write lookup that hits a clean entry raises an event, so that the page table can be brought up to date.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup with `lk_valid_i` high reports a miss.
- R2: The set is `va[15:12]` and the tag is `va[31:16]`. Four translations with different tags and the same set are all held at the same time.
- R3: Lookup is combinational. With `lk_valid_i` high and a matching valid entry, `lk_hit_o`=1 and `lk_pa_o` = {stored frame, `va[11:0]`}. With no match, `lk_miss_o`=1 and `lk_pa_o`=0. With `lk_valid_i` low, both flags are 0 and `lk_pa_o`=0.
- R4: The address-space identifier is part of the match. Two entries with the same page number and different identifiers coexist, and a lookup with a different identifier misses.
- R5: A fill becomes visible to lookups after the next rising edge. A fill whose page number and identifier are already present overwrites that entry in place, so no duplicate is ever created.
- R6: The fill slot is the matching entry if there is one. Otherwise it is the lowest-numbered invalid way. Otherwise it is the tree pseudo-LRU victim, which uses 3 bits per set (root, ways 0/1 node, ways 2/3 node). Each node points to the side to replace. A hit or a fill turns the nodes on the path away from the way it used. When a hit and a fill fall in the same set in one cycle, the fill's update is the one kept.
- R7: An invalidate removes only the entry whose page number and identifier both match. All other entries stay.
- R8: An invalidate and a fill in the same cycle that name the same page number and identifier leave no entry for that key.
- R9: A flush clears all entries and all replacement state. A fill in the same cycle is dropped.
- R10: A write lookup (`lk_write_i`=1) that hits an entry whose dirty bit is clear raises `lk_dirty_evt_o` in the same cycle, and that entry's dirty bit is set at the next edge. A fill loads the dirty bit from `fill_dirty_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Virtual address to translate |
| lk_asid_i | input | 8 | Address-space identifier of the lookup |
| lk_write_i | input | 1 | Lookup is for a write access |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No translation, start a walk |
| lk_pa_o | output | 32 | Physical address on a hit, else 0 |
| lk_dirty_evt_o | output | 1 | Write hit a clean entry |
| fill_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Page number to install |
| fill_asid_i | input | 8 | Identifier to install |
| fill_pfn_i | input | 20 | Frame number to install |
| fill_dirty_i | input | 1 | Dirty bit to install |
| inv_i | input | 1 | Remove one translation |
| inv_vpn_i | input | 20 | Page number to remove |
| inv_asid_i | input | 8 | Identifier to remove |
| flush_i | input | 1 | Clear all translations |

## Verification
The lookup flags, the physical address and the dirty event are all due in the same cycle as the lookup inputs. The bench drives inputs on the falling edge and compares the outputs one time unit later, before the next rising edge. Fills, invalidates, flushes and dirty-bit updates only become visible to lookups issued after the next rising edge. The bench's reference model therefore applies them just after that edge, using the same same-cycle precedence as the requirements: dirty mark, then fill, then invalidate, with flush above all. Directed sequences pin down the pseudo-LRU victim choice, the identifier separation and the collision cases with literal expected values. A long pseudo-random sweep over two sets, six tags and two identifiers then forces frequent evictions and overlapping commands.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int DEF_VPN_W  = 20;
  localparam int DEF_OFF_W  = 12;
  localparam int DEF_SET_W  = 4;
  localparam int DEF_WAYS   = 4;
  localparam int DEF_ASID_W = 8;
  localparam int DEF_PFN_W  = 20;

  typedef enum logic [1:0] {
    SRC_MATCH = 2'd0,
    SRC_FREE  = 2'd1,
    SRC_PLRU  = 2'd2
  } fill_src_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 16,
  parameter int ASID_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]              valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]   tags_i,
  input  logic [WAYS-1:0][ASID_W-1:0]  asids_i,
  input  logic [TAG_W-1:0]             key_tag_i,
  input  logic [ASID_W-1:0]            key_asid_i,
  output logic [WAYS-1:0]              hit_vec_o,
  output logic                         hit_o,
  output logic [WAY_W-1:0]             way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == key_tag_i) &&
                          (asids_i[w] == key_asid_i);
  end

  assign hit_o = |hit_vec_o;

  // at most one way matches, so OR-encoding is exact
  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec_o[w]) way_o = way_o | WAY_W'(w);
  end
endmodule

// File: rtl/xlat_plru.sv
module xlat_plru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SEL_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             a_en_i,
  input  logic [SEL_W-1:0] a_set_i,
  input  logic [WAY_W-1:0] a_way_i,
  input  logic             b_en_i,
  input  logic [SEL_W-1:0] b_set_i,
  input  logic [WAY_W-1:0] b_way_i,
  input  logic [SEL_W-1:0] q_set_i,
  output logic [WAY_W-1:0] q_victim_o
);
  // heap-ordered nodes: node n stored at bit n-1, node value = side to replace
  logic [WAYS-2:0] tree_q [SETS];

  function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] t,
                                            input logic [WAY_W-1:0] w);
    int node;
    node = WAYS + int'(w);
    for (int l = 0; l < WAY_W; l++) begin
      t[(node >> 1) - 1] = ((node % 2) == 0);
      node = node >> 1;
    end
    return t;
  endfunction

  function automatic logic [WAY_W-1:0] pick(input logic [WAYS-2:0] t);
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++)
      node = node * 2 + int'(t[node - 1]);
    return WAY_W'(node - WAYS);
  endfunction

  assign q_victim_o = pick(tree_q[q_set_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      if (b_en_i && !(a_en_i && (a_set_i == b_set_i)))
        tree_q[b_set_i] <= touch(tree_q[b_set_i], b_way_i);
      if (a_en_i)
        tree_q[a_set_i] <= touch(tree_q[a_set_i], a_way_i);
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W  = DEF_VPN_W,
  parameter int OFF_W  = DEF_OFF_W,
  parameter int SET_W  = DEF_SET_W,
  parameter int WAYS   = DEF_WAYS,
  parameter int ASID_W = DEF_ASID_W,
  parameter int PFN_W  = DEF_PFN_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lk_valid_i,
  input  logic [VPN_W+OFF_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0]        lk_asid_i,
  input  logic                     lk_write_i,
  output logic                     lk_hit_o,
  output logic                     lk_miss_o,
  output logic [PFN_W+OFF_W-1:0]   lk_pa_o,
  output logic                     lk_dirty_evt_o,
  input  logic                     fill_i,
  input  logic [VPN_W-1:0]         fill_vpn_i,
  input  logic [ASID_W-1:0]        fill_asid_i,
  input  logic [PFN_W-1:0]         fill_pfn_i,
  input  logic                     fill_dirty_i,
  input  logic                     inv_i,
  input  logic [VPN_W-1:0]         inv_vpn_i,
  input  logic [ASID_W-1:0]        inv_asid_i,
  input  logic                     flush_i
);
  localparam int TAG_W = VPN_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0]             dirty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][ASID_W-1:0] asid_q  [SETS];
  logic [WAYS-1:0][PFN_W-1:0]  pfn_q   [SETS];

  logic [SET_W-1:0] lk_set, fl_set, iv_set;
  logic [TAG_W-1:0] lk_tag, fl_tag, iv_tag;

  assign lk_set = lk_va_i[OFF_W +: SET_W];
  assign lk_tag = lk_va_i[OFF_W+SET_W +: TAG_W];
  assign fl_set = fill_vpn_i[SET_W-1:0];
  assign fl_tag = fill_vpn_i[VPN_W-1:SET_W];
  assign iv_set = inv_vpn_i[SET_W-1:0];
  assign iv_tag = inv_vpn_i[VPN_W-1:SET_W];

  // lookup port
  logic [WAYS-1:0]  lk_hit_vec;
  logic             lk_any;
  logic [WAY_W-1:0] lk_way;

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_lk_match (
    .valid_i    (valid_q[lk_set]),
    .tags_i     (tag_q[lk_set]),
    .asids_i    (asid_q[lk_set]),
    .key_tag_i  (lk_tag),
    .key_asid_i (lk_asid_i),
    .hit_vec_o  (lk_hit_vec),
    .hit_o      (lk_any),
    .way_o      (lk_way)
  );

  assign lk_hit_o       = lk_valid_i && lk_any;
  assign lk_miss_o      = lk_valid_i && !lk_any;
  assign lk_pa_o        = lk_hit_o ? {pfn_q[lk_set][lk_way], lk_va_i[OFF_W-1:0]} : '0;
  assign lk_dirty_evt_o = lk_hit_o && lk_write_i && !dirty_q[lk_set][lk_way];

  // fill port: reuse a matching slot to avoid duplicates
  logic [WAYS-1:0]  fl_hit_vec;
  logic             fl_any;
  logic [WAY_W-1:0] fl_match_way;

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_fl_match (
    .valid_i    (valid_q[fl_set]),
    .tags_i     (tag_q[fl_set]),
    .asids_i    (asid_q[fl_set]),
    .key_tag_i  (fl_tag),
    .key_asid_i (fill_asid_i),
    .hit_vec_o  (fl_hit_vec),
    .hit_o      (fl_any),
    .way_o      (fl_match_way)
  );

  logic             free_any;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_q[fl_set][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
  end

  logic             fill_do, fill_kill;
  logic [WAY_W-1:0] plru_way, fl_way;
  fill_src_e        fl_src;

  assign fill_kill = inv_i && (inv_vpn_i == fill_vpn_i) && (inv_asid_i == fill_asid_i);
  assign fill_do   = fill_i && !fill_kill && !flush_i;

  always_comb begin
    if (fl_any)        fl_src = SRC_MATCH;
    else if (free_any) fl_src = SRC_FREE;
    else               fl_src = SRC_PLRU;
    case (fl_src)
      SRC_MATCH: fl_way = fl_match_way;
      SRC_FREE:  fl_way = free_way;
      default:   fl_way = plru_way;
    endcase
  end

  xlat_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .a_en_i     (fill_do),
    .a_set_i    (fl_set),
    .a_way_i    (fl_way),
    .b_en_i     (lk_hit_o),
    .b_set_i    (lk_set),
    .b_way_i    (lk_way),
    .q_set_i    (fl_set),
    .q_victim_o (plru_way)
  );

  // invalidate port
  logic [WAYS-1:0]  iv_hit_vec;
  logic             iv_any, iv_do;
  logic [WAY_W-1:0] iv_way;

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_iv_match (
    .valid_i    (valid_q[iv_set]),
    .tags_i     (tag_q[iv_set]),
    .asids_i    (asid_q[iv_set]),
    .key_tag_i  (iv_tag),
    .key_asid_i (inv_asid_i),
    .hit_vec_o  (iv_hit_vec),
    .hit_o      (iv_any),
    .way_o      (iv_way)
  );

  assign iv_do = inv_i && iv_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (fill_do) valid_q[fl_set][fl_way] <= 1'b1;
      if (iv_do)   valid_q[iv_set][iv_way] <= 1'b0;
    end
  end

  // payload needs no reset: only read behind a valid bit
  always_ff @(posedge clk_i) begin
    if (lk_dirty_evt_o) dirty_q[lk_set][lk_way] <= 1'b1;
    if (fill_do) begin
      dirty_q[fl_set][fl_way] <= fill_dirty_i;
      tag_q[fl_set][fl_way]   <= fl_tag;
      asid_q[fl_set][fl_way]  <= fill_asid_i;
      pfn_q[fl_set][fl_way]   <= fill_pfn_i;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int WAYS   = 4,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lk_valid_i,
  input logic [VPN_W+OFF_W-1:0] lk_va_i,
  input logic [ASID_W-1:0]      lk_asid_i,
  input logic                   lk_write_i,
  input logic                   lk_hit_o,
  input logic                   lk_miss_o,
  input logic [PFN_W+OFF_W-1:0] lk_pa_o,
  input logic                   lk_dirty_evt_o,
  input logic                   fill_i,
  input logic [VPN_W-1:0]       fill_vpn_i,
  input logic [ASID_W-1:0]      fill_asid_i,
  input logic [PFN_W-1:0]       fill_pfn_i,
  input logic                   inv_i,
  input logic [VPN_W-1:0]       inv_vpn_i,
  input logic [ASID_W-1:0]      inv_asid_i,
  input logic                   flush_i,
  input logic [WAYS-1:0]        lk_hit_vec
);
  logic [VPN_W-1:0] lk_vpn;
  assign lk_vpn = lk_va_i[VPN_W+OFF_W-1:OFF_W];

  p_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o || lk_miss_o) == lk_valid_i && !(lk_hit_o && lk_miss_o));

  p_offset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_pa_o[OFF_W-1:0] == lk_va_i[OFF_W-1:0]);

  p_no_dup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit_vec));

  p_fill_visible_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_i && !inv_i && !flush_i) && lk_valid_i &&
     lk_vpn == $past(fill_vpn_i) && lk_asid_i == $past(fill_asid_i))
    |-> (lk_hit_o && lk_pa_o[PFN_W+OFF_W-1:OFF_W] == $past(fill_pfn_i)));

  p_inv_gone_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inv_i) && lk_valid_i && lk_vpn == $past(inv_vpn_i) &&
     lk_asid_i == $past(inv_asid_i)) |-> !lk_hit_o);

  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o);

  p_dirty_evt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_dirty_evt_o |-> (lk_hit_o && lk_write_i));
endmodule

bind xlat_cache xlat_cache_chk #(
  .VPN_W(VPN_W), .OFF_W(OFF_W), .WAYS(WAYS), .ASID_W(ASID_W), .PFN_W(PFN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_va_i(lk_va_i),
  .lk_asid_i(lk_asid_i), .lk_write_i(lk_write_i), .lk_hit_o(lk_hit_o),
  .lk_miss_o(lk_miss_o), .lk_pa_o(lk_pa_o), .lk_dirty_evt_o(lk_dirty_evt_o),
  .fill_i(fill_i), .fill_vpn_i(fill_vpn_i), .fill_asid_i(fill_asid_i),
  .fill_pfn_i(fill_pfn_i), .inv_i(inv_i), .inv_vpn_i(inv_vpn_i),
  .inv_asid_i(inv_asid_i), .flush_i(flush_i), .lk_hit_vec(lk_hit_vec)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        lk_valid, lk_write, lk_hit, lk_miss, lk_evt;
  logic [31:0] lk_va, lk_pa;
  logic [7:0]  lk_asid;
  logic        fill, fill_dirty, inv, flush;
  logic [19:0] fill_vpn, fill_pfn, inv_vpn;
  logic [7:0]  fill_asid, inv_asid;

  xlat_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_asid_i(lk_asid), .lk_write_i(lk_write),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_pa_o(lk_pa), .lk_dirty_evt_o(lk_evt),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid), .fill_pfn_i(fill_pfn),
    .fill_dirty_i(fill_dirty), .inv_i(inv), .inv_vpn_i(inv_vpn), .inv_asid_i(inv_asid),
    .flush_i(flush)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  bit          m_v [16][4];
  bit          m_d [16][4];
  logic [15:0] m_tag [16][4];
  logic [7:0]  m_asid [16][4];
  logic [19:0] m_pfn [16][4];
  bit   [2:0]  m_t [16];   // [0] root, [1] ways 0/1, [2] ways 2/3

  function automatic bit m_find(int s, logic [15:0] t, logic [7:0] a, output int w);
    w = 0;
    for (int i = 0; i < 4; i++)
      if (m_v[s][i] && m_tag[s][i] == t && m_asid[s][i] == a) begin
        w = i;
        return 1'b1;
      end
    return 1'b0;
  endfunction

  function automatic void m_touch(int s, int w);
    if (w < 2) begin
      m_t[s][0] = 1'b1;
      m_t[s][1] = (w == 0);
    end else begin
      m_t[s][0] = 1'b0;
      m_t[s][2] = (w == 2);
    end
  endfunction

  function automatic int m_victim(int s);
    if (m_t[s][0] == 1'b0) return m_t[s][1] ? 1 : 0;
    return m_t[s][2] ? 3 : 2;
  endfunction

  task automatic idle();
    lk_valid = 0; lk_write = 0; lk_va = '0; lk_asid = '0;
    fill = 0; fill_dirty = 0; fill_vpn = '0; fill_pfn = '0; fill_asid = '0;
    inv = 0; inv_vpn = '0; inv_asid = '0; flush = 0;
  endtask

  task automatic compare(string tag);
    int w; bit f; bit eh, em, ee; logic [31:0] ep;
    f  = m_find(int'(lk_va[15:12]), lk_va[31:16], lk_asid, w);
    eh = lk_valid && f;
    em = lk_valid && !f;
    ep = eh ? {m_pfn[int'(lk_va[15:12])][w], lk_va[11:0]} : 32'h0;
    ee = eh && lk_write && !m_d[int'(lk_va[15:12])][w];
    checks++;
    if (lk_hit !== eh || lk_miss !== em || lk_pa !== ep || lk_evt !== ee) begin
      errors++;
      $display("FAIL %s: hit/miss/pa/evt got %b %b %h %b exp %b %b %h %b",
               tag, lk_hit, lk_miss, lk_pa, lk_evt, eh, em, ep, ee);
    end
  endtask

  task automatic model_update();
    int lw, fw, iw, ls, fs, is_;
    bit lf, ff, inf, evt, fdo;
    ls = int'(lk_va[15:12]); fs = int'(fill_vpn[3:0]); is_ = int'(inv_vpn[3:0]);
    lf  = m_find(ls, lk_va[31:16], lk_asid, lw);
    evt = lk_valid && lf && lk_write && !m_d[ls][lw];
    fdo = fill && !(inv && inv_vpn == fill_vpn && inv_asid == fill_asid) && !flush;
    ff  = m_find(fs, fill_vpn[19:4], fill_asid, fw);
    if (!ff) begin
      fw = -1;
      for (int i = 3; i >= 0; i--) if (!m_v[fs][i]) fw = i;
      if (fw < 0) fw = m_victim(fs);
    end
    inf = inv && m_find(is_, inv_vpn[19:4], inv_asid, iw);
    if (flush) begin
      for (int s = 0; s < 16; s++) begin
        m_t[s] = '0;
        for (int i = 0; i < 4; i++) m_v[s][i] = 0;
      end
    end else begin
      if (evt) m_d[ls][lw] = 1;
      if (lk_valid && lf && !(fdo && fs == ls)) m_touch(ls, lw);
      if (fdo) begin
        m_v[fs][fw] = 1; m_d[fs][fw] = fill_dirty; m_tag[fs][fw] = fill_vpn[19:4];
        m_asid[fs][fw] = fill_asid; m_pfn[fs][fw] = fill_pfn;
        m_touch(fs, fw);
      end
      if (inf) m_v[is_][iw] = 0;
    end
  endtask

  // inputs already set at a falling edge
  task automatic cyc(string tag);
    #1 compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic chk_lit(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic probe(string tag, bit v, bit wr, logic [15:0] t, int s, logic [7:0] a,
                       bit eh, logic [19:0] epfn, bit ee);
    lk_valid = v; lk_write = wr; lk_va = {t, 4'(s), 12'h5a4}; lk_asid = a;
    #1;
    chk_lit(tag, {29'b0, lk_hit, lk_miss, lk_evt}, {29'b0, eh, v && !eh, ee});
    if (eh) chk_lit(tag, lk_pa, {epfn, 12'h5a4});
    compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic do_fill(string tag, logic [15:0] t, int s, logic [7:0] a,
                         logic [19:0] pfn, bit d);
    fill = 1; fill_vpn = {t, 4'(s)}; fill_asid = a; fill_pfn = pfn; fill_dirty = d;
    cyc(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    idle();
    for (int s = 0; s < 16; s++) begin
      m_t[s] = '0;
      for (int i = 0; i < 4; i++) begin m_v[s][i] = 0; m_d[s][i] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    probe("R1", 1, 0, 16'h0001, 5, 8'd1, 0, 20'h0, 0);

    // R2: four tags in one set coexist
    for (int t = 1; t <= 4; t++) do_fill("R2", 16'(t), 5, 8'd1, 20'(32'h100 + t), 1);
    for (int t = 1; t <= 4; t++) probe("R2", 1, 0, 16'(t), 5, 8'd1, 1, 20'(32'h100 + t), 0);

    // R6: victim after accesses 0,1,2,3 is way 0 (tag 1)
    do_fill("R6", 16'd5, 5, 8'd1, 20'h105, 1);
    probe("R6", 1, 0, 16'd1, 5, 8'd1, 0, 20'h0, 0);
    for (int t = 2; t <= 5; t++) probe("R6", 1, 0, 16'(t), 5, 8'd1, 1, 20'(32'h100 + t), 0);
    // touches 1,2,3,0 -> tree points to way 2 (tag 3), not the true LRU way 1
    do_fill("R6", 16'd6, 5, 8'd1, 20'h106, 1);
    probe("R6", 1, 0, 16'd3, 5, 8'd1, 0, 20'h0, 0);
    probe("R6", 1, 0, 16'd2, 5, 8'd1, 1, 20'h102, 0);

    // R4: identifier separates entries
    do_fill("R4", 16'd7, 6, 8'd1, 20'h301, 1);
    probe("R4", 1, 0, 16'd7, 6, 8'd2, 0, 20'h0, 0);
    do_fill("R4", 16'd7, 6, 8'd2, 20'h302, 1);
    probe("R4", 1, 0, 16'd7, 6, 8'd1, 1, 20'h301, 0);
    probe("R4", 1, 0, 16'd7, 6, 8'd2, 1, 20'h302, 0);

    // R5: refill overwrites in place
    do_fill("R5", 16'd7, 6, 8'd1, 20'h3aa, 1);
    probe("R5", 1, 0, 16'd7, 6, 8'd1, 1, 20'h3aa, 0);
    probe("R5", 1, 0, 16'd7, 6, 8'd2, 1, 20'h302, 0);

    // R7: single invalidate
    inv = 1; inv_vpn = {16'd7, 4'd6}; inv_asid = 8'd2;
    cyc("R7");
    probe("R7", 1, 0, 16'd7, 6, 8'd2, 0, 20'h0, 0);
    probe("R7", 1, 0, 16'd7, 6, 8'd1, 1, 20'h3aa, 0);

    // R8: invalidate beats same-key fill
    fill = 1; fill_vpn = {16'd9, 4'd7}; fill_asid = 8'd3; fill_pfn = 20'h777;
    inv = 1; inv_vpn = {16'd9, 4'd7}; inv_asid = 8'd3;
    cyc("R8");
    probe("R8", 1, 0, 16'd9, 7, 8'd3, 0, 20'h0, 0);

    // R10: dirty event once per clean entry
    do_fill("R10", 16'd1, 8, 8'd1, 20'h055, 0);
    probe("R10", 1, 0, 16'd1, 8, 8'd1, 1, 20'h055, 0);
    probe("R10", 1, 1, 16'd1, 8, 8'd1, 1, 20'h055, 1);
    probe("R10", 1, 1, 16'd1, 8, 8'd1, 1, 20'h055, 0);
    probe("R10", 1, 1, 16'd2, 5, 8'd1, 1, 20'h102, 0);

    // R3: no request, no flags
    probe("R3", 0, 0, 16'd1, 8, 8'd1, 0, 20'h0, 0);

    // R9: flush drops everything, including a same-cycle fill
    flush = 1; fill = 1; fill_vpn = {16'd4, 4'd9}; fill_asid = 8'd1; fill_pfn = 20'h999;
    cyc("R9");
    probe("R9", 1, 0, 16'd4, 9, 8'd1, 0, 20'h0, 0);
    probe("R9", 1, 0, 16'd7, 6, 8'd1, 0, 20'h0, 0);
    probe("R9", 1, 0, 16'd1, 8, 8'd1, 0, 20'h0, 0);

    // sweep: R3 R5 R6 R7 R8 R10 under overlapping commands
    r = 32'h1badcafe;
    for (int n = 0; n < NRAND; n++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      lk_valid = r[0] | r[1];
      lk_write = r[2];
      lk_va    = {13'h0, 3'(r[5:3] % 6), (r[6] ? 4'd9 : 4'd2), r[18:7]};
      lk_asid  = r[19] ? 8'd2 : 8'd1;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      fill      = (r[1:0] == 2'b00);
      fill_vpn  = {13'h0, 3'(r[4:2] % 6), (r[5] ? 4'd9 : 4'd2)};
      fill_asid = r[6] ? 8'd2 : 8'd1;
      fill_pfn  = r[26:7];
      fill_dirty = r[27];
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      inv      = (r[2:0] == 3'b000);
      inv_vpn  = {13'h0, 3'(r[5:3] % 6), (r[6] ? 4'd9 : 4'd2)};
      inv_asid = r[7] ? 8'd2 : 8'd1;
      flush    = (r[15:8] == 8'h00);
      cyc("R3/R6 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule